// File: doc/BRIEF.md
# Streaming Positional Popcount Engine

The engine counts set bits vertically. It takes a stream of byte blocks and keeps one running counter for each bit position. After any run of blocks, counter j holds the number of accepted bytes whose bit j was 1. Each block carries up to eight bytes and a lane count that says how many of them are real. The remaining lanes are forced to zero, so they add nothing.

Inside, each accepted block is placed into an 8x8 bit grid with the unused lanes zeroed. The grid is transposed so that row j collects bit j of every byte. Each row is popcounted, and each popcount is widened and added to the accumulator for that bit position. All of this happens in the cycle the block is accepted.

A clear input starts a new pass. A block flagged as last closes the pass: the engine raises a done flag and refuses further blocks until the next clear. The counters are read one at a time through a select-driven read port.

Top module: `pospop_engine`

## Requirements
- R1: After reset all counters read zero, `done_o` is low and `blk_ready_o` is high.
- R2: For every accepted byte in a used lane, counter j grows by bit j of that byte, for j from 0 to 7. Lane k occupies bits [8k+7:8k] of `blk_data_i`.
- R3: Lanes with index greater than or equal to `blk_cnt_i` contribute nothing, whatever data they carry.
- R4: A lane count of 0 adds nothing. A lane count above 8 is treated as 8.
- R5: A block is accepted on a rising edge where `blk_valid_i` and `blk_ready_o` are both high. Its contribution shows on `rd_cnt_o` after that edge and not before it.
- R6: Each counter is ACC_W bits wide (default 32) and wraps modulo 2^ACC_W.
- R7: While `clr_i` is high, `blk_ready_o` is low. At the next edge all counters become zero and done is cleared. A block presented in the same cycle as the clear is dropped.
- R8: `done_o` rises after the edge that accepts a block with `blk_last_i` high. It stays high until a clear, and `blk_ready_o` stays low meanwhile, so the counters do not change.
- R9: `rd_cnt_o` shows the counter for bit position `rd_sel_i` (0 to 7), read combinationally from the registered counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Start a new pass: zero counters and done |
| blk_valid_i | input | 1 | Block present |
| blk_ready_o | output | 1 | Engine can take a block this cycle |
| blk_data_i | input | 64 | Eight byte lanes, lane k in bits [8k+7:8k] |
| blk_cnt_i | input | 4 | Number of used lanes (0..8, larger clipped to 8) |
| blk_last_i | input | 1 | Block closes the pass |
| rd_sel_i | input | 3 | Bit position of the counter to read |
| rd_cnt_o | output | 32 | Selected counter value |
| done_o | output | 1 | Last block has been accumulated |

## Verification
Clear and block acceptance can fall in the same cycle. The bench provokes this by asserting `clr_i` together with a valid block of all-ones bytes. It then checks that `blk_ready_o` was low and that every counter reads zero afterwards, so the block left no trace. The second coincidence is a block arriving while done is high: the bench offers one and checks that the counters are unchanged. Expected counts come from an arithmetic per-bit model in the bench. The bench uses a narrow accumulator, so wrap-around is reached within a short run.

// File: rtl/pospop_pkg.sv
`timescale 1ns/1ps
package pospop_pkg;
    // Clip a lane count to the number of lanes in a block.
    function automatic int unsigned clip_lanes(input int unsigned cnt, input int unsigned lanes);
        return (cnt > lanes) ? lanes : cnt;
    endfunction
endpackage

// File: rtl/pospop_grid_load.sv
`timescale 1ns/1ps
module pospop_grid_load #(
    parameter int LANES  = 8,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES*BYTE_W-1:0] data_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic [LANES*BYTE_W-1:0] grid_o
);
    import pospop_pkg::*;

    int unsigned used;

    always_comb begin
        used = clip_lanes(int'(cnt_i), LANES);
    end

    // Start from a zeroed grid; copy only the lanes the count covers.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (k < used) grid_o[k*BYTE_W +: BYTE_W] = data_i[k*BYTE_W +: BYTE_W];
            else          grid_o[k*BYTE_W +: BYTE_W] = '0;
        end
    end

    // R3: masking only ever drops ones, never adds them
    always_comb begin
        a_r3_mask_only_drops: assert ($countones(grid_o) <= $countones(data_i))
            else $error("grid holds more ones than the input");
    end
endmodule

// File: rtl/pospop_transpose.sv
`timescale 1ns/1ps
module pospop_transpose #(
    parameter int LANES  = 8,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0] grid_i,
    output logic [BYTE_W*LANES-1:0] rows_o
);
    // Row j gathers bit j of every lane.
    for (genvar j = 0; j < BYTE_W; j++) begin : g_row
        for (genvar k = 0; k < LANES; k++) begin : g_col
            assign rows_o[j*LANES + k] = grid_i[k*BYTE_W + j];
        end
    end

    // R2: a transpose neither creates nor loses set bits
    always_comb begin
        a_r2_transpose_keeps_ones: assert ($countones(rows_o) == $countones(grid_i))
            else $error("transpose changed the number of set bits");
    end
endmodule

// File: rtl/pospop_lane_popcnt.sv
`timescale 1ns/1ps
module pospop_lane_popcnt #(
    parameter int LANES = 8,
    localparam int POP_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] row_i,
    output logic [POP_W-1:0] pop_o
);
    always_comb begin
        pop_o = '0;
        for (int i = 0; i < LANES; i++) begin
            pop_o = pop_o + POP_W'(row_i[i]);
        end
    end

    // R4: one row can never count more than one bit per lane
    always_comb begin
        a_r4_pop_bounded: assert (int'(pop_o) <= LANES)
            else $error("row popcount exceeds lane count");
    end
endmodule

// File: rtl/pospop_engine.sv
`timescale 1ns/1ps
module pospop_engine #(
    parameter int LANES  = 8,
    parameter int BYTE_W = 8,
    parameter int ACC_W  = 32,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int SEL_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    blk_valid_i,
    output logic                    blk_ready_o,
    input  logic [LANES*BYTE_W-1:0] blk_data_i,
    input  logic [CNT_W-1:0]        blk_cnt_i,
    input  logic                    blk_last_i,
    input  logic [SEL_W-1:0]        rd_sel_i,
    output logic [ACC_W-1:0]        rd_cnt_o,
    output logic                    done_o
);
    localparam int POP_W = $clog2(LANES + 1);

    typedef struct packed {
        logic [BYTE_W*ACC_W-1:0] acc;
        logic                    done;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [LANES*BYTE_W-1:0] grid;
    logic [BYTE_W*LANES-1:0] rows;
    logic [POP_W-1:0]        pop [BYTE_W];
    logic                    fire;

    pospop_grid_load #(.LANES(LANES), .BYTE_W(BYTE_W)) u_load (
        .data_i (blk_data_i),
        .cnt_i  (blk_cnt_i),
        .grid_o (grid)
    );

    pospop_transpose #(.LANES(LANES), .BYTE_W(BYTE_W)) u_xpose (
        .grid_i (grid),
        .rows_o (rows)
    );

    for (genvar j = 0; j < BYTE_W; j++) begin : g_pop
        pospop_lane_popcnt #(.LANES(LANES)) u_pop (
            .row_i (rows[j*LANES +: LANES]),
            .pop_o (pop[j])
        );
    end

    assign blk_ready_o = !st_q.done && !clr_i;
    assign fire        = blk_valid_i && blk_ready_o;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc  = '0;
            st_d.done = 1'b0;
        end else if (fire) begin
            for (int j = 0; j < BYTE_W; j++) begin
                st_d.acc[j*ACC_W +: ACC_W] = st_q.acc[j*ACC_W +: ACC_W] + ACC_W'(pop[j]);
            end
            if (blk_last_i) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_cnt_o = st_q.acc[rd_sel_i*ACC_W +: ACC_W];
    assign done_o   = st_q.done;

    // R7: a clear leaves every counter at zero
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.acc == '0 && !st_q.done));

    // R8: done holds until a clear
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clr_i) |=> st_q.done);

    // R8: no block is taken while done is high
    a_r8_no_take_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !blk_ready_o);

    // R8: accepting the last block raises done
    a_r8_last_raises_done: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_i && blk_ready_o && blk_last_i) |=> done_o);

    // R5: counters move only on acceptance or clear
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!(blk_valid_i && blk_ready_o) && !clr_i) |=> $stable(st_q.acc));
endmodule

// File: tb/sim_pospop_engine.sv
`timescale 1ns/1ps
module sim_pospop_engine;
    localparam int ACC_W = 6;
    localparam int MASK  = (1 << ACC_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        valid = 1'b0;
    logic        ready;
    logic [63:0] data = '0;
    logic [3:0]  cnt = '0;
    logic        last = 1'b0;
    logic [2:0]  sel = '0;
    logic [ACC_W-1:0] rdv;
    logic        done;

    int tests = 0;
    int fails = 0;
    int expc [8];
    logic done_m = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    pospop_engine #(.ACC_W(ACC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .blk_valid_i(valid),
        .blk_ready_o(ready), .blk_data_i(data), .blk_cnt_i(cnt),
        .blk_last_i(last), .rd_sel_i(sel), .rd_cnt_o(rdv), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_all(input string req);
        for (int j = 0; j < 8; j++) begin
            sel = 3'(j);
            #0.1;
            chk(req, int'(rdv), expc[j]);
        end
    endtask

    task automatic model_add(input logic [63:0] d, input int c);
        int used = (c > 8) ? 8 : c;
        for (int k = 0; k < used; k++)
            for (int j = 0; j < 8; j++)
                expc[j] = (expc[j] + int'(d[k*8 + j])) & MASK;
    endtask

    task automatic send(input logic [63:0] d, input int c, input logic l, input string req);
        logic take;
        @(negedge clk);
        data = d; cnt = 4'(c); last = l; valid = 1'b1;
        take = !done_m;
        #0.1;
        chk({req, " ready"}, int'(ready), int'(take));
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0; last = 1'b0;
        if (take) begin
            model_add(d, c);
            if (l) done_m = 1'b1;
        end
        chk_all(req);
    endtask

    task automatic do_clear(input logic with_block);
        @(negedge clk);
        clr = 1'b1;
        if (with_block) begin
            valid = 1'b1; data = '1; cnt = 4'd8;
            #0.1;
            chk("R7 ready low during clear", int'(ready), 0);
        end
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0; valid = 1'b0;
        for (int j = 0; j < 8; j++) expc[j] = 0;
        done_m = 1'b0;
        chk("R7 done cleared", int'(done), 0);
        chk_all("R7 counters cleared");
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        for (int j = 0; j < 8; j++) expc[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1 reset state
        chk("R1 ready after reset", int'(ready), 1);
        chk("R1 done after reset", int'(done), 0);
        chk_all("R1 counters after reset");

        // R2 R9: walking single bit through every lane and bit position
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 8; j++)
                send(64'd1 << (k*8 + j), 8, 1'b0, "R2 R9 walking bit");

        // R5: new value absent before the accepting edge, present after
        do_clear(1'b0);
        @(negedge clk);
        data = 64'h0000_0000_0000_0001; cnt = 4'd1; valid = 1'b1;
        sel = 3'd0;
        #0.1;
        chk("R5 not visible before edge", int'(rdv), 0);
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        sel = 3'd0;
        #0.1;
        chk("R5 visible after edge", int'(rdv), 1);
        expc[0] = 1;

        // R3 R4: all lanes full of ones, every lane count 0..15
        do_clear(1'b0);
        for (int c = 0; c < 16; c++)
            send('1, c, 1'b0, "R3 R4 count sweep");

        // R3: junk above the count with a fixed pattern
        do_clear(1'b0);
        send(64'hFFFF_FFFF_FFFF_FF5A, 1, 1'b0, "R3 masked lanes");

        // R2: pseudo-random blocks and counts
        do_clear(1'b0);
        for (int n = 0; n < 200; n++) begin
            logic [63:0] d;
            rng = step(rng); d[31:0] = rng;
            rng = step(rng); d[63:32] = rng;
            rng = step(rng);
            send(d, int'(rng[3:0]), 1'b0, "R2 random blocks");
        end

        // R6: wrap at 2^ACC_W
        do_clear(1'b0);
        for (int n = 0; n < 8; n++) send('1, 8, 1'b0, "R6 wrap");
        chk("R6 counter wrapped to zero", expc[3], 0);
        send('1, 8, 1'b0, "R6 after wrap");

        // R7: clear and block in the same cycle
        do_clear(1'b1);

        // R8: last block, then a refused block, then reopen
        send(64'h0102_0408_1020_4080, 8, 1'b1, "R8 last block");
        chk("R8 done raised", int'(done), 1);
        send('1, 8, 1'b0, "R8 refused after done");
        chk("R8 done held", int'(done), 1);
        do_clear(1'b0);
        #0.1;
        chk("R8 ready after clear", int'(ready), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule